// File: doc/BRIEF.md
# Classic Handshake Bus Master Engine

This block is a bus master for a classic (non-pipelined) handshake bus built on cycle, strobe, write-enable and termination signals. A client hands it one command at a time over a valid/ready interface. The block turns each command into bus activity, waits for the slave to end each transfer with acknowledge, error or retry, and returns one result per transfer. Each result carries the read data, a 2-bit status and the index of the transfer within the command.

There are three command kinds. A single command does one read or one write. A block command does two or more transfers in one direction, all inside one cycle assertion, and steps the address by the bus width in bytes after each transfer. A read-modify-write command reads a word, replaces the bits selected by a mask with a supplied value, and writes the result back to the same address, all inside one cycle assertion. Write data for single and block writes is pulled from a data port, one word per transfer. An error or retry response ends the command at once, and the block does not issue the transfer again. The data width may be 8, 16, 32 or 64 bits.

Top module: `wbc_master_engine`

## Requirements
- R1: When rst_n is low at a clock edge, cyc_o, stb_o and rsp_valid are low after that edge. After reset, cmd_ready is high.
- R2: stb_o is high only while cyc_o is high. If stb_o is high and no termination arrives, cyc_o is still high on the next cycle.
- R3: While stb_o is high and ack_i, err_i and rty_i are all low, adr_o, dat_o, sel_o, we_o and tag_o keep their values on the next cycle.
- R4: A transfer ends on the clock edge where stb_o is high together with one termination input. This holds both for a termination in the first strobe cycle and for one that comes any number of cycles later. On the next cycle rsp_valid pulses for one cycle. rsp_status is 0 for acknowledge, 1 for error and 2 for retry. For reads, rsp_data is the dat_i value sampled at the terminating edge.
- R5: After a command is accepted, cyc_o rises with stb_o low for exactly one cycle, and then stb_o rises. cyc_o falls on the edge after the last termination.
- R6: A block command (cmd_kind 1) does max(cmd_count, 2) transfers, all in the direction given by cmd_we. The first transfer uses cmd_addr, and each later one uses the previous address plus DW/8. stb_o is low for exactly one cycle between transfers while cyc_o stays high.
- R7: A read-modify-write command (cmd_kind 2) reads from cmd_addr with we_o low. It then writes to the same address with we_o high. The write data is (read_data & ~cmd_mask) | (cmd_wdata & cmd_mask). Both transfers happen inside one cyc_o assertion.
- R8: An error or retry termination on any transfer drops cyc_o and stb_o on the next cycle. That result has rsp_last high and carries that transfer's index. No further transfer of the command is issued.
- R9: For each write transfer of a single command (cmd_kind 0) or a block command, wdat_take pulses for one cycle while stb_o is low, before the transfer's strobe. wdat_in sampled in that cycle is the dat_o of that transfer. A read-modify-write never pulses wdat_take.
- R10: A command is accepted on an edge where cmd_valid and cmd_ready are both high. cmd_ready is high only when no bus cycle is in progress.
- R11: rsp_index counts transfers from 0 within each command. rsp_last is high exactly on the final result of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_kind | input | 2 | 0 single, 1 block, 2 read-modify-write (3 acts as single) |
| cmd_addr | input | AW | Byte address of the first transfer |
| cmd_count | input | CW | Transfer count for block commands |
| cmd_we | input | 1 | Direction for single and block commands, 1 = write |
| cmd_sel | input | DW/8 | Byte select driven for the whole command |
| cmd_tag | input | TW | Tag driven for the whole command |
| cmd_wdata | input | DW | Replacement value for read-modify-write |
| cmd_mask | input | DW | Bits replaced by read-modify-write |
| wdat_take | output | 1 | Write data word is being taken from wdat_in |
| wdat_in | input | DW | Write data for single and block writes |
| cyc_o | output | 1 | Bus cycle in progress |
| stb_o | output | 1 | Transfer strobe |
| we_o | output | 1 | Transfer is a write |
| adr_o | output | AW | Transfer address |
| dat_o | output | DW | Write data |
| sel_o | output | DW/8 | Byte select |
| tag_o | output | TW | Command tag |
| dat_i | input | DW | Read data from slave |
| ack_i | input | 1 | Normal termination |
| err_i | input | 1 | Error termination |
| rty_i | input | 1 | Retry termination |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | DW | Data sampled at termination |
| rsp_status | output | 2 | 0 ack, 1 err, 2 rty |
| rsp_index | output | CW | Transfer index within the command |
| rsp_last | output | 1 | Final result of the command |

## Verification
The assertions check the bus rules on every cycle: reset clears the cycle, the strobe stays inside the cycle, address, data, select, direction and tag stay stable while a strobe waits, the bus stops after an error or retry, the engine is ready only while idle, and a result never appears without a termination. Other properties need a model of the whole command, so only the bench scenarios can show them. These are the address stepping, the transfer count with short counts raised to two, the merge arithmetic, the order in which write words are pulled, the one-cycle lead and gap before each strobe, and the result indexing. The bench uses a slave model that has its own memory, adds configurable wait states and injects a fault at a chosen transfer.

// File: rtl/wbc_pkg.sv
// Shared encodings for the classic bus master engine.
package wbc_pkg;
    typedef enum logic [1:0] {
        KIND_SINGLE = 2'd0,
        KIND_BLOCK  = 2'd1,
        KIND_RMW    = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        RSP_ACK = 2'd0,
        RSP_ERR = 2'd1,
        RSP_RTY = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LEAD = 2'd1,
        S_XFER = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wbc_seq.sv
// Sequencer: owns cyc/stb, the transfer index and the per-command plan.
// Assumes the slave raises at most one termination at a time; if several
// are raised, error wins over retry, and retry wins over acknowledge.
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_we,
    input  logic          ack_i,
    input  logic          err_i,
    input  logic          rty_i,
    output logic          cmd_ready,
    output logic          cyc_o,
    output logic          stb_o,
    output logic          accept,
    output logic          wdat_take,
    output logic          step,
    output logic          rmw_turn,
    output logic          term,
    output logic [1:0]    term_status,
    output logic [CW-1:0] term_idx,
    output logic          term_last
);
    seq_state_e    state_q;
    kind_e         kind_q;
    logic          we_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] last_idx_q;
    logic          ok;
    logic          is_last;

    // Handshake and per-transfer decode.
    always_comb begin
        cmd_ready   = (state_q == S_IDLE);
        accept      = cmd_ready && cmd_valid;
        term        = stb_o && (ack_i || err_i || rty_i);
        term_status = err_i ? RSP_ERR : (rty_i ? RSP_RTY : RSP_ACK);
        ok          = (term_status == RSP_ACK);
        is_last     = (idx_q == last_idx_q);
        term_last   = !ok || is_last;
        term_idx    = idx_q;
        wdat_take   = (state_q == S_LEAD) && we_q && (kind_q != KIND_RMW);
        step        = term && ok && !is_last && (kind_q == KIND_BLOCK);
        rmw_turn    = term && ok && !is_last && (kind_q == KIND_RMW);
    end

    // State, strobe and cycle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cyc_o      <= 1'b0;
            stb_o      <= 1'b0;
            kind_q     <= KIND_SINGLE;
            we_q       <= 1'b0;
            idx_q      <= '0;
            last_idx_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    state_q <= S_LEAD;
                    cyc_o   <= 1'b1;
                    idx_q   <= '0;
                    case (cmd_kind)
                        KIND_BLOCK: begin
                            kind_q     <= KIND_BLOCK;
                            we_q       <= cmd_we;
                            last_idx_q <= (cmd_count < CW'(2)) ? CW'(1) : cmd_count - 1'b1;
                        end
                        KIND_RMW: begin
                            kind_q     <= KIND_RMW;
                            we_q       <= 1'b0;
                            last_idx_q <= CW'(1);
                        end
                        default: begin
                            kind_q     <= KIND_SINGLE;
                            we_q       <= cmd_we;
                            last_idx_q <= '0;
                        end
                    endcase
                end
                S_LEAD: begin
                    stb_o   <= 1'b1;
                    state_q <= S_XFER;
                end
                S_XFER: if (term) begin
                    stb_o <= 1'b0;
                    if (term_last) begin
                        cyc_o   <= 1'b0;
                        state_q <= S_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_LEAD;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbc_dpath.sv
// Datapath: address, data, select, direction and tag registers.
// Registers change only at accept, at a lead cycle or at a termination
// edge, so they are stable while a strobe waits.
module wbc_dpath
    import wbc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int TW = 4,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [1:0]    cmd_kind,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_we,
    input  logic [SW-1:0] cmd_sel,
    input  logic [TW-1:0] cmd_tag,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] cmd_mask,
    input  logic          wdat_take,
    input  logic [DW-1:0] wdat_in,
    input  logic          step,
    input  logic          rmw_turn,
    input  logic [DW-1:0] dat_i,
    output logic [AW-1:0] adr_o,
    output logic [DW-1:0] dat_o,
    output logic          we_o,
    output logic [SW-1:0] sel_o,
    output logic [TW-1:0] tag_o
);
    logic [DW-1:0] mask_q;
    logic [DW-1:0] val_q;
    logic [DW-1:0] merged;

    // Per-byte-lane merge of read data with the masked replacement value.
    for (genvar b = 0; b < SW; b++) begin : g_lane
        assign merged[b*8 +: 8] = (dat_i[b*8 +: 8] & ~mask_q[b*8 +: 8])
                                | (val_q[b*8 +: 8] & mask_q[b*8 +: 8]);
    end

    // Bus-side register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_o  <= '0;
            dat_o  <= '0;
            we_o   <= 1'b0;
            sel_o  <= '0;
            tag_o  <= '0;
            mask_q <= '0;
            val_q  <= '0;
        end else if (accept) begin
            adr_o  <= cmd_addr;
            we_o   <= (cmd_kind == KIND_RMW) ? 1'b0 : cmd_we;
            sel_o  <= cmd_sel;
            tag_o  <= cmd_tag;
            mask_q <= cmd_mask;
            val_q  <= cmd_wdata;
        end else if (wdat_take) begin
            dat_o  <= wdat_in;
        end else if (step) begin
            adr_o  <= adr_o + AW'(SW);
        end else if (rmw_turn) begin
            we_o   <= 1'b1;
            dat_o  <= merged;
        end
    end
endmodule

// File: rtl/wbc_resp.sv
// Result register: one pulse per terminated transfer, one cycle after it.
module wbc_resp #(
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          term,
    input  logic [1:0]    term_status,
    input  logic [CW-1:0] term_idx,
    input  logic          term_last,
    input  logic [DW-1:0] dat_i,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [1:0]    rsp_status,
    output logic [CW-1:0] rsp_index,
    output logic          rsp_last
);
    // Capture the termination and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_status <= '0;
            rsp_index  <= '0;
            rsp_last   <= 1'b0;
        end else begin
            rsp_valid <= term;
            if (term) begin
                rsp_data   <= dat_i;
                rsp_status <= term_status;
                rsp_index  <= term_idx;
                rsp_last   <= term_last;
            end
        end
    end
endmodule

// File: rtl/wbc_master_engine.sv
// Classic-mode bus master engine. It runs single, block and
// read-modify-write commands and reports one result per transfer.
// Assumes DW is 8, 16, 32 or 64 and that the slave uses the same width.
module wbc_master_engine #(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int TW = 4,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_kind,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_we,
    input  logic [SW-1:0] cmd_sel,
    input  logic [TW-1:0] cmd_tag,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] cmd_mask,
    output logic          wdat_take,
    input  logic [DW-1:0] wdat_in,
    output logic          cyc_o,
    output logic          stb_o,
    output logic          we_o,
    output logic [AW-1:0] adr_o,
    output logic [DW-1:0] dat_o,
    output logic [SW-1:0] sel_o,
    output logic [TW-1:0] tag_o,
    input  logic [DW-1:0] dat_i,
    input  logic          ack_i,
    input  logic          err_i,
    input  logic          rty_i,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [1:0]    rsp_status,
    output logic [CW-1:0] rsp_index,
    output logic          rsp_last
);
    if (!(DW == 8 || DW == 16 || DW == 32 || DW == 64)) begin : g_bad_width
        $error("data width must be 8, 16, 32 or 64");
    end

    logic          accept;
    logic          step;
    logic          rmw_turn;
    logic          term;
    logic [1:0]    term_status;
    logic [CW-1:0] term_idx;
    logic          term_last;

    wbc_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_count(cmd_count), .cmd_we(cmd_we), .ack_i(ack_i), .err_i(err_i),
        .rty_i(rty_i), .cmd_ready(cmd_ready), .cyc_o(cyc_o), .stb_o(stb_o),
        .accept(accept), .wdat_take(wdat_take), .step(step), .rmw_turn(rmw_turn),
        .term(term), .term_status(term_status), .term_idx(term_idx),
        .term_last(term_last)
    );

    wbc_dpath #(.DW(DW), .AW(AW), .TW(TW)) u_dpath (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_tag(cmd_tag),
        .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask), .wdat_take(wdat_take),
        .wdat_in(wdat_in), .step(step), .rmw_turn(rmw_turn), .dat_i(dat_i),
        .adr_o(adr_o), .dat_o(dat_o), .we_o(we_o), .sel_o(sel_o), .tag_o(tag_o)
    );

    wbc_resp #(.DW(DW), .CW(CW)) u_resp (
        .clk(clk), .rst_n(rst_n), .term(term), .term_status(term_status),
        .term_idx(term_idx), .term_last(term_last), .dat_i(dat_i),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
        .rsp_index(rsp_index), .rsp_last(rsp_last)
    );
endmodule

// File: rtl/wbc_master_checker.sv
// Protocol checker for the master engine, attached by bind below.
module wbc_master_checker #(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int TW = 4,
    localparam int SW = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          cyc_o,
    input logic          stb_o,
    input logic          we_o,
    input logic [AW-1:0] adr_o,
    input logic [DW-1:0] dat_o,
    input logic [SW-1:0] sel_o,
    input logic [TW-1:0] tag_o,
    input logic          ack_i,
    input logic          err_i,
    input logic          rty_i,
    input logic          rsp_valid,
    input logic          rsp_last
);
    p_reset_drop_r1: assert property (@(posedge clk)
        !rst_n |=> (!cyc_o && !stb_o && !rsp_valid));

    p_stb_in_cyc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> cyc_o);

    p_cyc_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && !ack_i && !err_i && !rty_i) |=> cyc_o);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && !ack_i && !err_i && !rty_i) |=>
        ($stable(adr_o) && $stable(dat_o) && $stable(sel_o) && $stable(we_o) && $stable(tag_o)));

    p_rsp_after_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(stb_o && (ack_i || err_i || rty_i)));

    p_fail_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && (err_i || rty_i)) |=> (!cyc_o && !stb_o));

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !cyc_o);

    p_more_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |-> cyc_o);
endmodule

bind wbc_master_engine wbc_master_checker #(.DW(DW), .AW(AW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cyc_o(cyc_o), .stb_o(stb_o),
    .we_o(we_o), .adr_o(adr_o), .dat_o(dat_o), .sel_o(sel_o), .tag_o(tag_o),
    .ack_i(ack_i), .err_i(err_i), .rty_i(rty_i), .rsp_valid(rsp_valid),
    .rsp_last(rsp_last)
);

// File: tb/tb_wbc_master_engine.sv
module tb_wbc_master_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int TW = 4;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_kind = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic cmd_we = 1'b0;
    logic [SW-1:0] cmd_sel = '1;
    logic [TW-1:0] cmd_tag = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [DW-1:0] cmd_mask = '0;
    logic wdat_take;
    logic [DW-1:0] wdat_in;
    logic cyc_o, stb_o, we_o;
    logic [AW-1:0] adr_o;
    logic [DW-1:0] dat_o;
    logic [SW-1:0] sel_o;
    logic [TW-1:0] tag_o;
    logic [DW-1:0] dat_i = '0;
    logic ack_i = 1'b0, err_i = 1'b0, rty_i = 1'b0;
    logic rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [1:0] rsp_status;
    logic [CW-1:0] rsp_index;
    logic rsp_last;

    wbc_master_engine #(.DW(DW), .AW(AW), .CW(CW), .TW(TW)) dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [DW-1:0] data;
        bit            chk_data;
        logic [1:0]    st;
        int            idx;
        bit            last;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;

    // Slave model state.
    logic [DW-1:0] smem [16];
    logic [DW-1:0] rmem [16];
    int s_wait = 0, s_fail_idx = -1, s_fail_code = 0, s_idx = 0, wc = 0;
    logic [AW-1:0] log_adr[$];
    logic          log_we[$];
    logic [DW-1:0] log_dat[$];
    int lead_cnt = 0;
    int wd_cnt = 0;

    assign wdat_in = 32'h5500_0000 + wd_cnt;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Slave response and read data, driven away from the active edge.
    always @(negedge clk) begin
        ack_i = 1'b0; err_i = 1'b0; rty_i = 1'b0;
        dat_i = smem[adr_o[5:2]];
        if (rst_n && cyc_o && stb_o) begin
            if (wc >= s_wait) begin
                int code;
                code = (s_idx == s_fail_idx) ? s_fail_code : 0;
                ack_i = (code == 0);
                err_i = (code == 1);
                rty_i = (code == 2);
                s_idx++;
                wc = 0;
            end else begin
                wc++;
            end
        end
    end

    // Bus logger, slave memory write and write-data supply counter.
    always @(posedge clk) begin
        if (rst_n && cyc_o && stb_o && (ack_i || err_i || rty_i)) begin
            log_adr.push_back(adr_o);
            log_we.push_back(we_o);
            log_dat.push_back(dat_o);
            if (ack_i && we_o) smem[adr_o[5:2]] <= dat_o;
        end
        if (rst_n && cyc_o && !stb_o) lead_cnt <= lead_cnt + 1;
        if (wdat_take) wd_cnt <= wd_cnt + 1;
    end

    // Scoreboard monitor: pops expected results as they appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected result", rsp_index, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_status == e.st, e.req, "status", rsp_status, e.st);
                check(rsp_index == CW'(e.idx), "R11", "index", rsp_index, e.idx);
                check(rsp_last == e.last, "R11", "last flag", rsp_last, e.last);
                if (e.chk_data)
                    check(rsp_data == e.data, "R4", "read data", rsp_data, e.data);
            end
        end
    end

    task automatic run_cmd(input int kind, input int addr, input int count,
                           input bit we, input logic [DW-1:0] val,
                           input logic [DW-1:0] mask, input int waits,
                           input int fidx, input int fcode, input string req);
        int n;
        int issued;
        int pred_wd;
        int log0;
        int lead0;
        logic [DW-1:0] rd;
        logic [AW-1:0] e_adr[$];
        bit            e_we[$];
        logic [DW-1:0] e_dat[$];
        n = (kind == 1) ? ((count < 2) ? 2 : count) : ((kind == 2) ? 2 : 1);
        issued = 0;
        pred_wd = wd_cnt;
        rd = '0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            logic [AW-1:0] a;
            bit w;
            int st;
            logic [DW-1:0] d;
            a = AW'(addr + ((kind == 1) ? i * SW : 0));
            w = (kind == 2) ? (i == 1) : we;
            st = (i == fidx) ? fcode : 0;
            d = '0;
            if (!w) rd = rmem[a[5:2]];
            if (w) begin
                if (kind == 2) d = (rd & ~mask) | (val & mask);
                else begin d = 32'h5500_0000 + pred_wd; pred_wd++; end
            end
            e.data = rmem[a[5:2]];
            e.chk_data = !w;
            e.st = 2'(st);
            e.idx = i;
            e.last = (st != 0) || (i == n - 1);
            e.req = req;
            exp_q.push_back(e);
            e_adr.push_back(a); e_we.push_back(w); e_dat.push_back(d);
            issued++;
            if (w && st == 0) rmem[a[5:2]] = d;
            if (st != 0) break;
        end
        log0 = log_adr.size();
        lead0 = lead_cnt;
        s_wait = waits; s_fail_idx = fidx; s_fail_code = fcode; s_idx = 0; wc = 0;
        @(negedge clk);
        cmd_kind = 2'(kind); cmd_addr = AW'(addr); cmd_count = CW'(count);
        cmd_we = we; cmd_wdata = val; cmd_mask = mask; cmd_tag = TW'(kind + 5);
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R10", "ready while busy", cmd_ready, 0);
        while (exp_q.size() != 0 || cyc_o) @(negedge clk);
        check(log_adr.size() - log0 == issued, req, "transfer count",
              log_adr.size() - log0, issued);
        check(lead_cnt - lead0 == issued, "R5", "strobe-low cycles", lead_cnt - lead0, issued);
        for (int i = 0; i < issued && log0 + i < log_adr.size(); i++) begin
            check(log_adr[log0 + i] == e_adr[i], (kind == 1) ? "R6" : req, "address",
                  log_adr[log0 + i], e_adr[i]);
            check(log_we[log0 + i] == e_we[i], (kind == 2) ? "R7" : req, "direction",
                  log_we[log0 + i], e_we[i]);
            if (e_we[i])
                check(log_dat[log0 + i] == e_dat[i], (kind == 2) ? "R7" : "R9", "write data",
                      log_dat[log0 + i], e_dat[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            smem[i] = 32'hC0DE_0000 + 32'(i * 17);
            rmem[i] = smem[i];
        end
        repeat (3) @(negedge clk);
        check(!cyc_o && !stb_o && !rsp_valid, "R1", "bus idle in reset",
              {cyc_o, stb_o, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);

        run_cmd(0, 'h08, 0, 0, '0, '0, 0, -1, 0, "R4");               // no-wait read
        run_cmd(0, 'h0C, 0, 1, '0, '0, 2, -1, 0, "R9");               // waited write
        run_cmd(0, 'h0C, 0, 0, '0, '0, 1, -1, 0, "R4");               // read back
        run_cmd(1, 'h10, 4, 0, '0, '0, 1, -1, 0, "R6");               // block read
        run_cmd(1, 'h20, 3, 1, '0, '0, 0, -1, 0, "R6");               // block write
        run_cmd(1, 'h20, 3, 0, '0, '0, 0, -1, 0, "R6");               // read block back
        run_cmd(1, 'h00, 1, 0, '0, '0, 0, -1, 0, "R6");               // short count -> 2
        run_cmd(2, 'h04, 0, 0, 32'h1234_ABCD, 32'h0000_FF0F, 1, -1, 0, "R7");
        run_cmd(0, 'h04, 0, 0, '0, '0, 0, -1, 0, "R7");               // merged word
        run_cmd(1, 'h30, 4, 1, '0, '0, 0, 1, 1, "R8");                // err mid-block
        run_cmd(2, 'h08, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 2, "R8"); // rty on read
        run_cmd(0, 'h3C, 0, 1, '0, '0, 3, 0, 2, "R8");                // rty on write
        run_cmd(1, 'h30, 4, 0, '0, '0, 2, -1, 0, "R8");               // only first written

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule